// File: doc/BRIEF.md
# Masked Event Combiner

The block collects single-cycle event pulses from up to 128 sources. It latches each pulse into a flag bit inside one of four groups of 32. Each group drives one combined event line. The line stays high as a level while any flag in the group is pending and not blocked by that group's interrupt mask. Software services an event in four steps: it reads a group's masked-flag view, picks a pending bit, writes a 1 to that bit of the group's clear register, and repeats until the combined line drops. Software can also raise any flag itself through a write-one set register.

Each group also carries an exception mask with its own masked view over the same flags. This second view is independent of the interrupt mask. It lets software poll a different subset of the flags without disturbing the combined lines. Event number n is held in group n/32, bit n mod 32.

A small per-group state machine drives each combined line. It has two states:
- `CMB_IDLE`: the line is low.
- `CMB_ASSERT`: the line is high.

It has two transitions:
- **raise**: `CMB_IDLE` to `CMB_ASSERT`, taken when the group has at least one unmasked pending flag.
- **drain**: `CMB_ASSERT` to `CMB_IDLE`, taken when no unmasked pending flag remains.

Top module: `evc_combiner`

## Requirements
- R1: After reset, every flag is 0, every interrupt mask and every exception mask is all-ones, every combined line is 0, and the read data output is 0.
- R2: A pulse on event input n sets flag bit n mod 32 of group n/32 at the clock edge that samples it. Flags hold their value until they are cleared.
- R3: Writing the set register of a group sets each flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R4: Writing the clear register of a group clears each flag whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R5: When a hardware pulse on a bit arrives in the same cycle as a clear of that bit, the flag ends up set.
- R6: A group's combined line is the OR of its flags ANDed with the inverted interrupt mask. A mask bit of 1 blocks its flag. The line follows the flag and mask registers one clock later, so it rises on the second edge after an event pulse. It stays high until no unmasked flag remains.
- R7: Reading the masked-flag register returns the flags ANDed with the inverted interrupt mask.
- R8: Reading the masked exception register returns the flags ANDed with the inverted exception mask. The exception mask has no effect on the combined lines, and the interrupt mask has no effect on this view.
- R9: Word address bits [4:3] select the group and bits [2:0] select the register:
  - 0: flags, read-only
  - 1: set, write-only
  - 2: clear, write-only
  - 3: interrupt mask, read/write
  - 4: masked flags, read-only
  - 5: exception mask, read/write
  - 6: masked exception flags, read-only
  - 7: reserved

  Writes to read-only offsets are ignored. Reads of offsets 1, 2 and 7 return 0.
- R10: The read data output loads at the clock edge where the read strobe is high, with the register values before that edge. It holds its value while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | Single-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address: group in [4:3], register in [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| comb_evt | output | 4 | Combined event line per group |

## Verification
The clash that matters is a hardware pulse on a flag landing in the same cycle as a software clear of that same bit. The bench provokes this by driving the event input and a clear-register write on the same falling edge. It then reads the flag word back and expects the bit to be set. The other clash is a clear of one bit while another masked-in bit of the same group is still pending. For that case the bench expects the combined line to stay high until the last pending bit is cleared.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Register selector within a group (low three address bits).
    typedef enum logic [2:0] {
        OFS_FLAG  = 3'd0,
        OFS_SET   = 3'd1,
        OFS_CLR   = 3'd2,
        OFS_MASK  = 3'd3,
        OFS_MFLAG = 3'd4,
        OFS_XMASK = 3'd5,
        OFS_XFLAG = 3'd6,
        OFS_RSVD  = 3'd7
    } reg_ofs_e;

    // Combined-line state per group.
    typedef enum logic {
        CMB_IDLE   = 1'b0,
        CMB_ASSERT = 1'b1
    } cmb_state_e;

    // Write strobes delivered to one group.
    typedef struct packed {
        logic set_we;
        logic clr_we;
        logic mask_we;
        logic xmask_we;
    } grp_wr_s;

endpackage

// File: rtl/evc_group.sv
module evc_group
    import evc_pkg::*;
#(
    parameter int GROUP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] evt_in,
    input  grp_wr_s            wr,
    input  logic [GROUP_W-1:0] wdata,
    output logic [GROUP_W-1:0] flag_q,
    output logic [GROUP_W-1:0] mask_q,
    output logic [GROUP_W-1:0] xmask_q,
    output logic [GROUP_W-1:0] mflag,
    output logic [GROUP_W-1:0] xflag,
    output logic               comb_evt
);

    logic [GROUP_W-1:0] set_bits;
    logic [GROUP_W-1:0] clr_bits;
    logic [GROUP_W-1:0] raise_bits;
    cmb_state_e         state_q;
    cmb_state_e         state_d;
    logic               any_pending;

    assign set_bits   = wr.set_we ? wdata : '0;
    assign clr_bits   = wr.clr_we ? wdata : '0;
    assign raise_bits = set_bits | evt_in;

    // Flag array: the clear is applied first, so any raise in the same cycle wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_bits) | raise_bits;
        end
    end

    // Interrupt mask and exception mask: 1 blocks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            xmask_q <= '1;
        end else begin
            if (wr.mask_we) begin
                mask_q <= wdata;
            end
            if (wr.xmask_we) begin
                xmask_q <= wdata;
            end
        end
    end

    assign mflag       = flag_q & ~mask_q;
    assign xflag       = flag_q & ~xmask_q;
    assign any_pending = |mflag;

    // Combined-line state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and output logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMB_IDLE:   if (any_pending)  state_d = CMB_ASSERT;
            CMB_ASSERT: if (!any_pending) state_d = CMB_IDLE;
        endcase
    end

    always_comb begin
        comb_evt = (state_q == CMB_ASSERT);
    end

    // Assertions guarding the flag array and the combined line.
    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (flag_q == '0 && mask_q == '1 && xmask_q == '1 && !comb_evt));

    assert_raise_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(raise_bits)) == $past(raise_bits)));

    assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(clr_bits & ~raise_bits)) == '0));

    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flag_q ^ $past(flag_q)) & ~$past(clr_bits | raise_bits)) == '0));

    assert_comb_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(comb_evt) |-> $past(any_pending));

    assert_comb_drops_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(comb_evt) |-> $past(mflag == '0));

endmodule

// File: rtl/evc_regif.sv
module evc_regif
    import evc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32,
    localparam int GSEL_W    = $clog2(NUM_GROUPS),
    localparam int ADDR_W    = GSEL_W + 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_wr,
    input  logic                                  bus_rd,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]    flag_q,
    input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]    mask_q,
    input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]    xmask_q,
    input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]    mflag,
    input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]    xflag,
    output grp_wr_s [NUM_GROUPS-1:0]              wr_strb,
    output logic [GROUP_W-1:0]                    bus_rdata
);

    localparam bit POW2 = (NUM_GROUPS == (1 << GSEL_W));

    logic [GSEL_W-1:0] grp_idx;
    reg_ofs_e          ofs;
    logic              grp_ok;
    logic [GROUP_W-1:0] rd_val;

    assign grp_idx = bus_addr[ADDR_W-1:3];
    assign ofs     = reg_ofs_e'(bus_addr[2:0]);

    generate
        if (POW2) begin : g_full
            assign grp_ok = 1'b1;
        end else begin : g_partial
            assign grp_ok = ({1'b0, grp_idx} < (GSEL_W + 1)'(NUM_GROUPS));
        end
    endgenerate

    // Write decode: one strobe per group and writable register.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            wr_strb[g] = '0;
            if (bus_wr && grp_ok && grp_idx == GSEL_W'(g)) begin
                unique case (ofs)
                    OFS_SET:   wr_strb[g].set_we   = 1'b1;
                    OFS_CLR:   wr_strb[g].clr_we   = 1'b1;
                    OFS_MASK:  wr_strb[g].mask_we  = 1'b1;
                    OFS_XMASK: wr_strb[g].xmask_we = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // Read select.
    always_comb begin
        rd_val = '0;
        if (grp_ok) begin
            unique case (ofs)
                OFS_FLAG:  rd_val = flag_q[grp_idx];
                OFS_MASK:  rd_val = mask_q[grp_idx];
                OFS_MFLAG: rd_val = mflag[grp_idx];
                OFS_XMASK: rd_val = xmask_q[grp_idx];
                OFS_XFLAG: rd_val = xflag[grp_idx];
                OFS_SET, OFS_CLR, OFS_RSVD: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strb));

    assert_no_strobe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (wr_strb == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/evc_combiner.sv
module evc_combiner
    import evc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32,
    localparam int NUM_EVT   = NUM_GROUPS * GROUP_W,
    localparam int ADDR_W    = $clog2(NUM_GROUPS) + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVT-1:0]    evt_in,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [GROUP_W-1:0]    bus_wdata,
    output logic [GROUP_W-1:0]    bus_rdata,
    output logic [NUM_GROUPS-1:0] comb_evt
);

    grp_wr_s [NUM_GROUPS-1:0]           wr_strb;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] flag_q;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] mask_q;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] xmask_q;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] mflag;
    logic [NUM_GROUPS-1:0][GROUP_W-1:0] xflag;

    evc_regif #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .flag_q    (flag_q),
        .mask_q    (mask_q),
        .xmask_q   (xmask_q),
        .mflag     (mflag),
        .xflag     (xflag),
        .wr_strb   (wr_strb),
        .bus_rdata (bus_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            evc_group #(
                .GROUP_W (GROUP_W)
            ) u_group (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_in   (evt_in[g*GROUP_W +: GROUP_W]),
                .wr       (wr_strb[g]),
                .wdata    (bus_wdata),
                .flag_q   (flag_q[g]),
                .mask_q   (mask_q[g]),
                .xmask_q  (xmask_q[g]),
                .mflag    (mflag[g]),
                .xflag    (xflag[g]),
                .comb_evt (comb_evt[g])
            );
        end
    endgenerate

endmodule

// File: tb/sim_evc_combiner.sv
module sim_evc_combiner;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] OP_NOP = 3'd0;
    localparam logic [2:0] OP_WR  = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_EV  = 3'd3;
    localparam logic [2:0] OP_CK  = 3'd4;

    // Row: op[75:73] addr[72:68] data[67:36] expect[35:4] req[3:0]
    localparam int NROWS = 39;
    localparam logic [75:0] TBL [NROWS] = '{
        {OP_RD,  5'd3,  32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask g0
        {OP_RD,  5'd16, 32'h0,        32'h00000000, 4'd1},  // R1 flags g2
        {OP_CK,  5'd0,  32'h0,        32'h00000000, 4'd1},  // R1 lines low
        {OP_EV,  5'd0,  32'd5,        32'h0,        4'd2},
        {OP_EV,  5'd0,  32'd70,       32'h0,        4'd2},
        {OP_RD,  5'd0,  32'h0,        32'h00000020, 4'd2},  // R2 g0 bit5
        {OP_RD,  5'd16, 32'h0,        32'h00000040, 4'd2},  // R2 g2 bit6
        {OP_CK,  5'd0,  32'h0,        32'h00000000, 4'd6},  // R6 masked
        {OP_WR,  5'd3,  32'hFFFFFFDF, 32'h0,        4'd6},
        {OP_NOP, 5'd0,  32'h0,        32'h0,        4'd6},
        {OP_CK,  5'd0,  32'h0,        32'h00000001, 4'd6},  // R6 g0 up
        {OP_RD,  5'd4,  32'h0,        32'h00000020, 4'd7},  // R7
        {OP_RD,  5'd6,  32'h0,        32'h00000000, 4'd8},  // R8 xmask all set
        {OP_WR,  5'd5,  32'hFFFFFFDF, 32'h0,        4'd8},
        {OP_RD,  5'd6,  32'h0,        32'h00000020, 4'd8},  // R8 view
        {OP_WR,  5'd3,  32'hFFFFFFFF, 32'h0,        4'd8},
        {OP_NOP, 5'd0,  32'h0,        32'h0,        4'd8},
        {OP_CK,  5'd0,  32'h0,        32'h00000000, 4'd8},  // R8 xmask no effect on line
        {OP_RD,  5'd6,  32'h0,        32'h00000020, 4'd8},  // R8 mask no effect on view
        {OP_WR,  5'd1,  32'h00000300, 32'h0,        4'd3},
        {OP_RD,  5'd0,  32'h0,        32'h00000320, 4'd3},  // R3
        {OP_WR,  5'd2,  32'h00000120, 32'h0,        4'd4},
        {OP_RD,  5'd0,  32'h0,        32'h00000200, 4'd4},  // R4
        {OP_WR,  5'd0,  32'hFFFFFFFF, 32'h0,        4'd9},
        {OP_RD,  5'd0,  32'h0,        32'h00000200, 4'd9},  // R9 RO ignored
        {OP_RD,  5'd1,  32'h0,        32'h00000000, 4'd9},  // R9 set reads 0
        {OP_RD,  5'd31, 32'h0,        32'h00000000, 4'd9},  // R9 reserved
        {OP_WR,  5'd11, 32'h00000000, 32'h0,        4'd6},
        {OP_WR,  5'd9,  32'h80000001, 32'h0,        4'd6},
        {OP_NOP, 5'd0,  32'h0,        32'h0,        4'd6},
        {OP_CK,  5'd0,  32'h0,        32'h00000002, 4'd6},  // R6 g1 up
        {OP_WR,  5'd10, 32'h00000001, 32'h0,        4'd6},
        {OP_NOP, 5'd0,  32'h0,        32'h0,        4'd6},
        {OP_CK,  5'd0,  32'h0,        32'h00000002, 4'd6},  // R6 one left
        {OP_WR,  5'd10, 32'h80000000, 32'h0,        4'd6},
        {OP_NOP, 5'd0,  32'h0,        32'h0,        4'd6},
        {OP_CK,  5'd0,  32'h0,        32'h00000000, 4'd6},  // R6 drained
        {OP_RD,  5'd20, 32'h0,        32'h00000000, 4'd7},  // R7 g2 masked
        {OP_RD,  5'd16, 32'h0,        32'h00000040, 4'd2}   // R2 g2 held
    };

    logic         clk;
    logic         rst_n;
    logic [127:0] evt_in;
    logic         bus_wr;
    logic         bus_rd;
    logic [4:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [3:0]   comb_evt;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    evc_combiner u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .comb_evt  (comb_evt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        evt_in    = '0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic do_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        idle_bus();
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_evt(input int n);
        evt_in[n] = 1'b1;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        idle_bus();
        rst_n = 1'b0;
        @(negedge clk);
        apply_reset();
        check("R1 rdata after reset", bus_rdata, 32'h0);

        // Table walk: one row per clock.
        for (int i = 0; i < NROWS; i++) begin
            logic [2:0]  op;
            logic [4:0]  a;
            logic [31:0] d;
            logic [31:0] e;
            logic [3:0]  rq;
            {op, a, d, e, rq} = TBL[i];
            if (op == OP_CK) check($sformatf("R%0d line row %0d", rq, i), {28'h0, comb_evt}, e);
            case (op)
                OP_WR: begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
                OP_RD: begin bus_rd = 1'b1; bus_addr = a; end
                OP_EV: evt_in[d[6:0]] = 1'b1;
                default: ;
            endcase
            @(negedge clk);
            idle_bus();
            if (op == OP_RD) check($sformatf("R%0d read row %0d", rq, i), bus_rdata, e);
        end

        // R2: highest event number lands in the last group, top bit.
        pulse_evt(127);
        do_read(5'd24, 32'h80000000, "R2 event 127");

        // R5: hardware pulse on g1 bit1 together with a clear of that bit.
        evt_in[33] = 1'b1;
        bus_wr = 1'b1; bus_addr = 5'd10; bus_wdata = 32'h00000002;
        @(negedge clk);
        idle_bus();
        do_read(5'd8, 32'h00000002, "R5 pulse beats clear");
        do_write(5'd10, 32'h00000002);
        do_read(5'd8, 32'h00000000, "R4 clear alone");

        // R10: read data holds while the read strobe is low.
        pulse_evt(32);
        repeat (2) @(negedge clk);
        check("R10 rdata held", bus_rdata, 32'h00000000);
        do_read(5'd8, 32'h00000001, "R10 fresh read");

        // g1 mask is 0 and bit0 pending: line is high before reset.
        check("R6 g1 line before reset", {28'h0, comb_evt}, 32'h00000002);

        // R1: mid-run reset.
        apply_reset();
        check("R1 lines after reset", {28'h0, comb_evt}, 32'h0);
        check("R1 rdata after mid reset", bus_rdata, 32'h0);
        do_read(5'd11, 32'hFFFFFFFF, "R1 g1 mask");
        do_read(5'd13, 32'hFFFFFFFF, "R1 g1 exception mask");
        do_read(5'd16, 32'h00000000, "R1 g2 flags");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule